// File: doc/BRIEF.md
# Interrupt Mask and Pending Controller

This block gathers 32 internal interrupt sources for a processor core. Each source has two event lines. A source's pending bit is set while any of its event lines is high. A software-writable enable register gates the pending bits. Among the sources that are both pending and enabled, the lowest-numbered one wins. The block sends that winner to the core as a registered request together with a vector code. Source positions in the enable register are fixed and never follow priority. The set of implemented sources is a 32-bit parameter. Unimplemented positions can never be enabled and never become pending.

There is one race case. Software may clear an enable bit in the same cycle that the matching pending bit has just started a request. In that case the request is not dropped silently. A sticky error flag is set instead. While no ordinary source is active, the core sees a reserved error vector, and no register setting can mask it. Asserting the acknowledge input for one cycle while the error vector is shown clears the flag. Ordinary pending bits clear only when their event lines go low.

A small state machine drives the output side. It has three states: IDLE (no request), REQ (an ordinary source is presented) and ERR (the error vector is presented). Its transitions are:
- IDLE to REQ, and ERR to REQ, when any enabled source is pending.
- IDLE to ERR, and REQ to ERR, when no enabled source is pending and the error flag is set.
- REQ to IDLE when neither is true.
- ERR to IDLE when no enabled source is pending and the error flag has been cleared by acknowledge.

Top module: `irq_gate_ctrl`

## Requirements
- R1: After reset the enable register reads 0, the error flag is clear, and irq_req_o is 0 with irq_vec_o 0, even while events are high.
- R2: A write to address 0 loads the enable register (1 enables a source, 0 disables it). Reading address 0 returns the enable register at any time.
- R3: Enable bits and pending bits at positions not set in IMPL_MASK read as 0, ignore writes, and never cause a request.
- R4: Pending bit i is a registered copy of the OR of evt_i[2i] and evt_i[2i+1]. It stays set until both lines are low. Reading address 1 returns the pending register regardless of the enable register.
- R5: irq_req_o is 1 exactly when irq_vec_o is nonzero. An ordinary vector equals the index of the winning source plus 1, in the range 1 to 32. The output changes one clock after the pending register and two clocks after an event line.
- R6: The lowest-numbered source that is both pending and enabled wins. A pending source that is disabled has no effect on the vector.
- R7: A write that clears enable bit i sets the error flag when pending bit i became 1 at the previous clock edge. With no enabled source pending, irq_vec_o then shows 63.
- R8: The error vector cannot be masked, because enable writes do not clear it. An ordinary active source is presented ahead of it, and the error vector returns once no ordinary source is active.
- R9: irq_ack_i clears the error flag only in a cycle where the error vector is being presented. In any other cycle it has no effect.
- R10: Writes to address 1 are ignored, and the pending register is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 64 | Event lines, two per source, lines 2i and 2i+1 belonging to source i |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 enable register, 1 pending register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the selected register |
| irq_ack_i | input | 1 | One-cycle acknowledge of the error vector |
| irq_req_o | output | 1 | Registered interrupt request to the core |
| irq_vec_o | output | 6 | Vector code: 0 none, 1..32 source index plus 1, 63 error |

## Verification
On every cycle, the assertions check the following:
- Unimplemented pending positions stay at zero.
- An enable write lands exactly as written.
- The request agrees with the vector.
- An ordinary state carries a code from 1 to 32.
- A raised error flag with no enabled source forces the error code on the next cycle.
- An acknowledge during the error state empties the flag.

Only the bench scenarios can show the following:
- The order in which sources win.
- The two-clock latency from an event line.
- That a pending bit holds while one of its event lines is still high.
- How the race behaves when it overlaps an ordinary request.
- That acknowledge has no effect while an ordinary vector hides the error.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int NSRC        = 32;
    localparam int EVT_PER_SRC = 2;
    localparam int VEC_W       = 6;
    localparam logic [VEC_W-1:0] VEC_NONE = '0;
    localparam logic [VEC_W-1:0] VEC_ERR  = '1;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_REQ  = 2'd1,
        S_ERR  = 2'd2
    } irq_state_e;

    function automatic logic [VEC_W-1:0] lowest_code(input logic [NSRC-1:0] act);
        logic [VEC_W-1:0] code;
        code = VEC_NONE;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (act[i]) code = VEC_W'(i + 1);
        end
        return code;
    endfunction
endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
    import irq_pkg::*;
#(
    parameter logic [NSRC-1:0] IMPL_MASK = 32'hFFFF_7FFF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_i,
    input  logic            addr_i,
    input  logic [NSRC-1:0] wdata_i,
    input  logic [NSRC-1:0] pend_i,
    output logic [NSRC-1:0] mask_o,
    output logic [NSRC-1:0] clr_o,
    output logic [NSRC-1:0] rdata_o
);
    logic [NSRC-1:0] mask_q;
    logic            mask_wr;

    assign mask_wr = wr_i && (addr_i == 1'b0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (mask_wr) begin
            mask_q <= wdata_i & IMPL_MASK;
        end
    end

    // bits going from enabled to disabled in this write
    assign clr_o   = mask_wr ? (mask_q & ~wdata_i) : '0;
    assign mask_o  = mask_q;
    assign rdata_o = addr_i ? pend_i : mask_q;

    AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !addr_i) |=> (mask_o == ($past(wdata_i) & IMPL_MASK))); // R2
endmodule

// File: rtl/irq_pend_stage.sv
module irq_pend_stage
    import irq_pkg::*;
#(
    parameter logic [NSRC-1:0] IMPL_MASK = 32'hFFFF_7FFF
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NSRC*EVT_PER_SRC-1:0] evt_i,
    input  logic [NSRC-1:0]             mask_i,
    input  logic [NSRC-1:0]             clr_i,
    output logic [NSRC-1:0]             pend_o,
    output logic [NSRC-1:0]             act_o,
    output logic                        race_o
);
    logic [NSRC-1:0] evt_any;
    logic [NSRC-1:0] pend_q;
    logic [NSRC-1:0] pend_prev_q;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        if (IMPL_MASK[g]) begin : g_impl
            assign evt_any[g] = |evt_i[g*EVT_PER_SRC +: EVT_PER_SRC];
        end else begin : g_hole
            assign evt_any[g] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q      <= '0;
            pend_prev_q <= '0;
        end else begin
            pend_q      <= evt_any;
            pend_prev_q <= pend_q;
        end
    end

    assign pend_o = pend_q;
    assign act_o  = pend_q & mask_i;
    // a source whose request has just started is being disabled
    assign race_o = |(clr_i & pend_q & ~pend_prev_q);

    AST_PEND_UNIMPL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_o & ~IMPL_MASK) == '0)); // R3
endmodule

// File: rtl/irq_vec_fsm.sv
module irq_vec_fsm
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  act_i,
    input  logic             race_i,
    input  logic             ack_i,
    output logic             req_o,
    output logic [VEC_W-1:0] vec_o
);
    irq_state_e       st_q, st_d;
    logic             err_q, err_d;
    logic [VEC_W-1:0] vec_q, vec_d;
    logic             any_act;

    assign any_act = |act_i;

    always_comb begin
        err_d = err_q;
        if (ack_i && st_q == S_ERR) err_d = 1'b0;
        if (race_i) err_d = 1'b1;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: begin
                if (any_act)    st_d = S_REQ;
                else if (err_d) st_d = S_ERR;
            end
            S_REQ: begin
                if (!any_act) st_d = err_d ? S_ERR : S_IDLE;
            end
            S_ERR: begin
                if (any_act)     st_d = S_REQ;
                else if (!err_d) st_d = S_IDLE;
            end
            default: st_d = S_IDLE;
        endcase
    end

    always_comb begin
        unique case (st_d)
            S_REQ:   vec_d = lowest_code(act_i);
            S_ERR:   vec_d = VEC_ERR;
            default: vec_d = VEC_NONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= S_IDLE;
            err_q <= 1'b0;
            vec_q <= VEC_NONE;
        end else begin
            st_q  <= st_d;
            err_q <= err_d;
            vec_q <= vec_d;
        end
    end

    always_comb begin
        req_o = (st_q != S_IDLE);
        vec_o = vec_q;
    end

    AST_REQ_MATCHES_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o == (vec_o != VEC_NONE))); // R5
    AST_NORMAL_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_REQ) |-> (vec_o >= VEC_W'(1) && vec_o <= VEC_W'(NSRC))); // R5
    AST_ERR_UNMASKABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !any_act && !(ack_i && st_q == S_ERR)) |=> (vec_o == VEC_ERR)); // R8
    AST_ACK_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && st_q == S_ERR && !race_i) |=> !err_q); // R9
endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl
    import irq_pkg::*;
#(
    parameter logic [31:0] IMPL_MASK = 32'hFFFF_7FFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [63:0] evt_i,
    input  logic        reg_wr_i,
    input  logic        reg_addr_i,
    input  logic [31:0] reg_wdata_i,
    output logic [31:0] reg_rdata_o,
    input  logic        irq_ack_i,
    output logic        irq_req_o,
    output logic [5:0]  irq_vec_o
);
    logic [NSRC-1:0] mask_w;
    logic [NSRC-1:0] clr_w;
    logic [NSRC-1:0] pend_w;
    logic [NSRC-1:0] act_w;
    logic            race_w;

    irq_mask_reg #(.IMPL_MASK(IMPL_MASK)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .pend_i  (pend_w),
        .mask_o  (mask_w),
        .clr_o   (clr_w),
        .rdata_o (reg_rdata_o)
    );

    irq_pend_stage #(.IMPL_MASK(IMPL_MASK)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .evt_i  (evt_i),
        .mask_i (mask_w),
        .clr_i  (clr_w),
        .pend_o (pend_w),
        .act_o  (act_w),
        .race_o (race_w)
    );

    irq_vec_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .act_i  (act_w),
        .race_i (race_w),
        .ack_i  (irq_ack_i),
        .req_o  (irq_req_o),
        .vec_o  (irq_vec_o)
    );
endmodule

// File: tb/irq_gate_ctrl_tb.sv
`timescale 1ns/1ps
module irq_gate_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] evt = '0;
    logic        wr = 1'b0;
    logic        addr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        ack = 1'b0;
    logic        req;
    logic [5:0]  vec;
    int          n_chk = 0;
    int          n_err = 0;
    logic        done = 1'b0;

    localparam logic [31:0] IMPL = 32'hFFFF_7FFF;

    always #2.5 clk = ~clk;

    irq_gate_ctrl #(.IMPL_MASK(IMPL)) dut_i (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .reg_wr_i(wr), .reg_addr_i(addr),
        .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_ack_i(ack),
        .irq_req_o(req), .irq_vec_o(vec)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reg_wr(input logic a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic reg_rd(input logic a, output logic [31:0] d);
        addr = a;
        #0.5;
        d = rdata;
    endtask

    task automatic t_reset;
        logic [31:0] d;
        reg_rd(1'b0, d);
        chk("R1 mask after reset", d, 32'h0);
        chk("R1 req after reset", {31'd0, req}, 32'd0);
        evt[0] = 1'b1;
        tick(2);
        chk("R1 masked event no request", {26'd0, vec}, 32'd0);
        reg_rd(1'b1, d);
        chk("R4 pending readable while masked", d, 32'h1);
        evt[0] = 1'b0;
        tick(2);
    endtask

    task automatic t_mask_rw;
        logic [31:0] d;
        reg_wr(1'b0, 32'hFFFF_FFFF);
        reg_rd(1'b0, d);
        chk("R2 R3 mask readback, hole at 15", d, IMPL);
        reg_wr(1'b0, 32'h0);
        reg_rd(1'b0, d);
        chk("R2 mask cleared", d, 32'h0);
    endtask

    task automatic t_basic_latency;
        reg_wr(1'b0, 32'h8);
        evt[6] = 1'b1;
        tick(1);
        chk("R5 not yet after one edge", {26'd0, vec}, 32'd0);
        tick(1);
        chk("R5 vector source 3", {26'd0, vec}, 32'd4);
        chk("R5 request high", {31'd0, req}, 32'd1);
    endtask

    task automatic t_priority;
        logic [31:0] d;
        evt[18] = 1'b1;
        reg_wr(1'b0, 32'h208);
        tick(2);
        chk("R6 lower index wins", {26'd0, vec}, 32'd4);
        reg_wr(1'b0, 32'h200);
        tick(1);
        chk("R6 disabled source ignored", {26'd0, vec}, 32'd10);
        reg_rd(1'b1, d);
        chk("R4 pending shows both", d, 32'h208);
    endtask

    task automatic t_multi_event;
        evt[19] = 1'b1;
        tick(2);
        evt[18] = 1'b0;
        tick(3);
        chk("R4 one line still high keeps pending", {26'd0, vec}, 32'd10);
        evt[19] = 1'b0;
        tick(2);
        chk("R4 both lines low clears", {26'd0, vec}, 32'd0);
        evt[6] = 1'b0;
        reg_wr(1'b0, 32'h0);
        tick(2);
    endtask

    task automatic t_unimpl;
        logic [31:0] d;
        reg_wr(1'b0, 32'hFFFF_FFFF);
        evt[30] = 1'b1;
        evt[31] = 1'b1;
        tick(2);
        reg_rd(1'b1, d);
        chk("R3 unimplemented pending zero", d, 32'h0);
        chk("R3 no request from hole", {26'd0, vec}, 32'd0);
        evt[30] = 1'b0; evt[31] = 1'b0;
        reg_wr(1'b0, 32'h0);
    endtask

    task automatic t_pend_ro;
        logic [31:0] d;
        evt[2] = 1'b1;
        tick(1);
        reg_wr(1'b1, 32'h0);
        reg_rd(1'b1, d);
        chk("R10 pending write ignored", d, 32'h2);
        reg_rd(1'b0, d);
        chk("R10 mask untouched by pending write", d, 32'h0);
        evt[2] = 1'b0;
        tick(2);
    endtask

    task automatic t_race_alone;
        reg_wr(1'b0, 32'h10);
        tick(1);
        evt[8] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr(1'b0, 32'h0);
        tick(1);
        chk("R7 race gives error vector", {26'd0, vec}, 32'd63);
        reg_wr(1'b0, 32'h1);
        tick(2);
        chk("R8 enable write does not mask error", {26'd0, vec}, 32'd63);
        ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ack = 1'b0;
        tick(1);
        chk("R9 ack clears error", {26'd0, vec}, 32'd0);
        chk("R9 request low after ack", {31'd0, req}, 32'd0);
        evt[8] = 1'b0;
        reg_wr(1'b0, 32'h0);
        tick(2);
    endtask

    task automatic t_race_hidden;
        evt[4] = 1'b1;
        reg_wr(1'b0, 32'h14);
        tick(2);
        evt[8] = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr(1'b0, 32'h4);
        tick(2);
        chk("R8 ordinary source ahead of error", {26'd0, vec}, 32'd3);
        ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ack = 1'b0;
        evt[4] = 1'b0;
        tick(3);
        chk("R9 ack outside error had no effect", {26'd0, vec}, 32'd63);
        ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ack = 1'b0;
        tick(1);
        chk("R9 ack in error clears", {26'd0, vec}, 32'd0);
        evt[8] = 1'b0;
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        t_reset();
        t_mask_rw();
        t_basic_latency();
        t_priority();
        t_multi_event();
        t_unimpl();
        t_pend_ro();
        t_race_alone();
        t_race_hidden();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule